// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control Register

This block holds the status and control word for one downstream port of a USB host controller root hub. The host driver reads the word over a simple register bus. Writes do not store data: the low bits carry command strobes (enable the port, disable the port), and the change flags in the upper half are cleared by writing ones to them. The block follows whether a device is attached, whether the port is enabled, and which of four change events has happened since the driver last acknowledged it.

Hardware conditions reach the block as inputs. An overcurrent, a power-off or a babble indication forces the port disabled. A detach does the same. A completed port reset or a completed resume from suspend enables a connected port and raises its own change flag. A tie-off marks the attached device as non-removable, so the port always reports it as connected. An interrupt line is raised while any change flag whose mask bit is set is pending.

Top module: `rh_port_status`

## Requirements
- R1: While reset is high and in the first cycle after it, the read word is all zero and the interrupt output is 0.
- R2: Bit 0 of the read word shows the connect status, registered one cycle after `dev_present` or `nonremovable`. It is 1 whenever `nonremovable` is 1, and no write changes it.
- R3: A change in connect status sets the connect-change flag (bit 16). A detach also clears the enable bit (bit 1) in the same cycle.
- R4: A write with bit 1 set enables a connected port. A write with bit 1 clear leaves the enable bit unchanged.
- R5: A write with bit 1 set while the connect status is 0 leaves the port disabled and sets the connect-change flag instead.
- R6: A write with bit 0 set disables the port. If bits 0 and 1 are both set in one write, the port ends up disabled.
- R7: Overcurrent, power-off or babble clears the enable bit. The enable-change flag (bit 17) is set only if the port was enabled.
- R8: A reset-done pulse sets the reset-change flag (bit 18) and a suspend-done pulse sets the suspend-change flag (bit 19). Either pulse enables the port if it is connected and leaves it disabled if it is not.
- R9: Each change flag is cleared by writing 1 to its bit and left alone by writing 0. An event that sets a flag wins over an acknowledge in the same cycle.
- R10: The interrupt output is registered. It equals the OR of the change flags ANDed with `irq_mask`, where mask bit i belongs to flag bit 16+i.
- R11: The enable bit is never 1 while the connect status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word: bit 0 disables, bit 1 enables, bits 19:16 acknowledge flags |
| rd_data | output | 32 | Status word: bit 0 connect, bit 1 enable, bits 19:16 change flags |
| dev_present | input | 1 | Device detected on the port |
| nonremovable | input | 1 | Attached device is fixed; forces connect status to 1 |
| overcurrent | input | 1 | Overcurrent condition |
| pwr_off | input | 1 | Port power switched off |
| babble | input | 1 | Bus error such as babble |
| reset_done | input | 1 | One-cycle pulse: port reset completed |
| suspend_done | input | 1 | One-cycle pulse: resume from suspend completed |
| irq_mask | input | 4 | Interrupt mask, one bit per change flag |
| irq | output | 1 | Masked OR of the change flags |

## Verification
A wrong internal state shows up on `rd_data` in the cycle after the event that caused it, because every status and flag bit is driven straight from a register. A wrong priority between a hardware disable and an enable command shows as bit 1 set after a fault cycle. A lost or duplicated change event shows as a flag in bits 19:16 that differs from what the event history predicts, and it stays wrong until the driver acknowledges it. A wrong mask or a wrong flag path reaches `irq` one edge after the flag change, so each check compares `irq` in the same cycle as the word.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  localparam int N_CHG = 4;

  // change-flag slots, offset from the change base bit
  localparam int CHG_CONN = 0;
  localparam int CHG_ENA  = 1;
  localparam int CHG_RST  = 2;
  localparam int CHG_SUSP = 3;

  typedef struct packed {
    logic             set_ena;
    logic             clr_ena;
    logic [N_CHG-1:0] ack;
  } port_cmd_t;
endpackage

// File: rtl/rh_port_cmd_dec.sv
module rh_port_cmd_dec
  import rh_port_pkg::*;
(
  input  logic             wr_en,
  input  logic [1:0]       wr_ctl,
  input  logic [N_CHG-1:0] wr_ack,
  output port_cmd_t        cmd
);
  always_comb begin
    cmd.clr_ena = wr_en & wr_ctl[0];
    cmd.set_ena = wr_en & wr_ctl[1];
    cmd.ack     = wr_en ? wr_ack : '0;
  end
endmodule

// File: rtl/rh_port_conn.sv
module rh_port_conn (
  input  logic clk,
  input  logic rst,
  input  logic dev_present,
  input  logic nonremovable,
  output logic ccs_q,
  output logic attach_ev,
  output logic detach_ev
);
  logic ccs_now;

  assign ccs_now   = dev_present | nonremovable;
  assign attach_ev = ccs_now & ~ccs_q;
  assign detach_ev = ~ccs_now & ccs_q;

  always_ff @(posedge clk) begin
    if (rst) ccs_q <= 1'b0;
    else     ccs_q <= ccs_now;
  end
endmodule

// File: rtl/rh_port_chg.sv
module rh_port_chg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] ack,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] flag_d
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // a setting event outranks a same-cycle acknowledge
    always_comb begin
      if (set[i])      flag_d[i] = 1'b1;
      else if (ack[i]) flag_d[i] = 1'b0;
      else             flag_d[i] = flag_q[i];
    end

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/rh_port_status.sv
module rh_port_status
  import rh_port_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CHG_BASE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dev_present,
  input  logic              nonremovable,
  input  logic              overcurrent,
  input  logic              pwr_off,
  input  logic              babble,
  input  logic              reset_done,
  input  logic              suspend_done,
  input  logic [N_CHG-1:0]  irq_mask,
  output logic              irq
);
  localparam int CHG_TOP = CHG_BASE + N_CHG - 1;

  port_cmd_t        cmd;
  logic             ccs_q, attach_ev, detach_ev;
  logic             pes_q, pes_d;
  logic             hw_dis;
  logic [N_CHG-1:0] chg_set, chg_q, chg_d;
  logic             irq_q;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[DATA_W-1:CHG_TOP+1], wr_data[CHG_BASE-1:2]};

  rh_port_cmd_dec u_dec (
    .wr_en  (wr_en),
    .wr_ctl (wr_data[1:0]),
    .wr_ack (wr_data[CHG_TOP:CHG_BASE]),
    .cmd    (cmd)
  );

  rh_port_conn u_conn (
    .clk          (clk),
    .rst          (rst),
    .dev_present  (dev_present),
    .nonremovable (nonremovable),
    .ccs_q        (ccs_q),
    .attach_ev    (attach_ev),
    .detach_ev    (detach_ev)
  );

  // hardware disable sources, detach included
  assign hw_dis = overcurrent | pwr_off | babble | detach_ev;

  always_comb begin
    if (hw_dis)
      pes_d = 1'b0;
    else if (cmd.clr_ena)
      pes_d = 1'b0;
    else if ((cmd.set_ena | reset_done | suspend_done) & ccs_q)
      pes_d = 1'b1;
    else
      pes_d = pes_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pes_q <= 1'b0;
    else     pes_q <= pes_d;
  end

  always_comb begin
    chg_set           = '0;
    chg_set[CHG_CONN] = attach_ev | detach_ev | (cmd.set_ena & ~ccs_q);
    chg_set[CHG_ENA]  = hw_dis & pes_q;
    chg_set[CHG_RST]  = reset_done;
    chg_set[CHG_SUSP] = suspend_done;
  end

  rh_port_chg #(.N(N_CHG)) u_chg (
    .clk    (clk),
    .rst    (rst),
    .set    (chg_set),
    .ack    (cmd.ack),
    .flag_q (chg_q),
    .flag_d (chg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(chg_d & irq_mask);
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[0]                 = ccs_q;
    rd_data[1]                 = pes_q;
    rd_data[CHG_TOP:CHG_BASE]  = chg_q;
  end

  assign irq = irq_q;
endmodule

// File: rtl/rh_port_status_chk.sv
module rh_port_status_chk
  import rh_port_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CHG_BASE = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              dev_present,
  input logic              nonremovable,
  input logic              overcurrent,
  input logic              pwr_off,
  input logic              babble,
  input logic              reset_done,
  input logic [N_CHG-1:0]  irq_mask,
  input logic              irq
);
  // R2
  ccs_follows_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rd_data[0] == $past(dev_present | nonremovable));

  // R5
  enable_needs_conn_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[1] && !rd_data[0]) |=> (!rd_data[1] && rd_data[CHG_BASE+CHG_CONN]));

  // R6
  clear_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[0]) |=> !rd_data[1]);

  // R7
  hw_disable_chk: assert property (@(posedge clk) disable iff (rst)
    (overcurrent || pwr_off || babble) |=> !rd_data[1]);

  // R9
  rst_flag_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[CHG_BASE+CHG_RST] && !reset_done) |=> !rd_data[CHG_BASE+CHG_RST]);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == |(rd_data[CHG_BASE +: N_CHG] & $past(irq_mask)));

  // R11
  enable_implies_conn_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[1] |-> rd_data[0]);
endmodule

bind rh_port_status rh_port_status_chk #(.DATA_W(DATA_W), .CHG_BASE(CHG_BASE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .dev_present  (dev_present),
  .nonremovable (nonremovable),
  .overcurrent  (overcurrent),
  .pwr_off      (pwr_off),
  .babble       (babble),
  .reset_done   (reset_done),
  .irq_mask     (irq_mask),
  .irq          (irq)
);

// File: tb/tb_rh_port_status.sv
`timescale 1ns/1ps
module tb_rh_port_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dev_present = 1'b0;
  logic        nonremovable = 1'b0;
  logic        overcurrent = 1'b0;
  logic        pwr_off = 1'b0;
  logic        babble = 1'b0;
  logic        reset_done = 1'b0;
  logic        suspend_done = 1'b0;
  logic [3:0]  irq_mask = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [31:0] exp_rd_q[$];
  logic        exp_irq_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  rh_port_status dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dev_present(dev_present), .nonremovable(nonremovable),
    .overcurrent(overcurrent), .pwr_off(pwr_off), .babble(babble),
    .reset_done(reset_done), .suspend_done(suspend_done),
    .irq_mask(irq_mask), .irq(irq)
  );

  // bit values used in the expectations
  localparam logic [31:0] CCS  = 32'h1;
  localparam logic [31:0] PES  = 32'h2;
  localparam logic [31:0] CSC  = 32'h1_0000;
  localparam logic [31:0] PESC = 32'h2_0000;
  localparam logic [31:0] PRSC = 32'h4_0000;
  localparam logic [31:0] PSSC = 32'h8_0000;

  // one clock with the inputs as set; push the expected result
  task automatic tick(input logic [31:0] e_rd, input logic e_irq, input string t);
    @(posedge clk);
    #1;
    exp_rd_q.push_back(e_rd);
    exp_irq_q.push_back(e_irq);
    tag_q.push_back(t);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    overcurrent = 1'b0; pwr_off = 1'b0; babble = 1'b0;
    reset_done = 1'b0; suspend_done = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d, input logic [31:0] e_rd, input logic e_irq, input string t);
    wr_en = 1'b1; wr_data = d;
    tick(e_rd, e_irq, t);
  endtask

  // monitor: compare every pending expectation away from the edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_rd_q.size() > 0) begin
        logic [31:0] er;
        logic        ei;
        string       t;
        er = exp_rd_q.pop_front();
        ei = exp_irq_q.pop_front();
        t  = tag_q.pop_front();
        checks++;
        if (rd_data !== er || irq !== ei) begin
          failures++;
          $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b", t, rd_data, irq, er, ei);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(32'h0, 1'b0, "R1 in reset");
    dev_present = 1'b1;
    tick(32'h0, 1'b0, "R1 reset holds");
    rst = 1'b0;
    dev_present = 1'b0;
    tick(32'h0, 1'b0, "R1 after reset");

    // attach, enable
    dev_present = 1'b1;
    tick(CSC | CCS, 1'b0, "R3 attach sets CSC");
    wr(PES, CSC | CCS | PES, 1'b0, "R4 set enable");
    wr(32'h0, CSC | CCS | PES, 1'b0, "R4 zero write no effect");
    wr(CSC, CCS | PES, 1'b0, "R9 ack CSC");

    // hardware faults
    overcurrent = 1'b1;
    tick(PESC | CCS, 1'b0, "R7 overcurrent disables");
    wr(PESC, CCS, 1'b0, "R9 ack PESC");
    overcurrent = 1'b1;
    tick(CCS, 1'b0, "R7 fault on disabled port no PESC");

    irq_mask = 4'b0010;
    wr(PES, CCS | PES, 1'b0, "R10 masked idle");
    babble = 1'b1;
    tick(PESC | CCS, 1'b1, "R7/R10 babble raises irq");
    wr(PES, PESC | CCS | PES, 1'b1, "R4 re-enable");
    wr(PES | 32'h1, PESC | CCS, 1'b1, "R6 clear wins over set");
    wr(PES, PESC | CCS | PES, 1'b1, "R4 enable again");
    wr(32'h1, PESC | CCS, 1'b1, "R6 clear enable");
    wr(PESC, CCS, 1'b0, "R10 ack drops irq");
    wr(PES, CCS | PES, 1'b0, "R4 enable");
    pwr_off = 1'b1;
    tick(PESC | CCS, 1'b1, "R7 power off disables");
    wr(PESC, CCS, 1'b0, "R9 ack PESC");

    // reset completion and detach
    reset_done = 1'b1;
    tick(PRSC | CCS | PES, 1'b0, "R8 reset done enables");
    irq_mask = 4'b0100;
    tick(PRSC | CCS | PES, 1'b1, "R10 mask change");
    dev_present = 1'b0;
    tick(CSC | PESC | PRSC, 1'b1, "R3 detach clears enable");
    irq_mask = 4'b0000;
    wr(CSC | PESC | PRSC, 32'h0, 1'b0, "R9 ack all");
    wr(PES, CSC, 1'b0, "R5 enable while disconnected");
    wr(PES | 32'h1, CSC, 1'b0, "R11 enable disconnected stays off");
    dev_present = 1'b1;
    wr(CSC, CSC | CCS, 1'b0, "R9 set wins over ack");
    wr(CSC, CCS, 1'b0, "R9 ack CSC");
    suspend_done = 1'b1;
    tick(PSSC | CCS | PES, 1'b0, "R8 suspend done enables");
    wr(PSSC | 32'h0, CCS | PES, 1'b0, "R9 ack PSSC");

    dev_present = 1'b0;
    tick(CSC | PESC, 1'b0, "R3 detach");
    wr(CSC | PESC, 32'h0, 1'b0, "R9 ack");
    reset_done = 1'b1;
    tick(PRSC, 1'b0, "R8 reset done not connected");
    wr(PRSC, 32'h0, 1'b0, "R9 ack PRSC");

    // non-removable device
    nonremovable = 1'b1;
    tick(CSC | CCS, 1'b0, "R2 nonremovable forces connect");
    wr(CSC | 32'h1, CCS, 1'b0, "R2 write leaves connect");
    wr(PES, CCS | PES, 1'b0, "R4 enable nonremovable");
    dev_present = 1'b1;
    tick(CCS | PES, 1'b0, "R2 no edge while fixed");
    dev_present = 1'b0;
    tick(CCS | PES, 1'b0, "R2 stays connected");
    irq_mask = 4'b1111;
    overcurrent = 1'b1;
    tick(PESC | CCS, 1'b1, "R10 full mask");

    @(negedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule